// File: doc/BRIEF.md
# 1-Wire ROM Search Accelerator

This block sits beside a 1-Wire slot engine and takes over the bit-level work of a ROM search. Once the host has reset the bus and sent the search command as an ordinary byte, it raises the enable input. From then on, each byte the host writes makes the block process four ROM bit positions. For each position the block asks the slot engine for two read slots: the first returns the identity bit and the second returns its complement. The block then decides which branch to follow and asks for a write slot that carries the chosen bit.

When the four positions are done, the block presents one byte that interleaves the four chosen bits with four discrepancy flags. It pulses a done strobe, the same way a normal received byte would be announced. Sixteen such exchanges walk a full 64-bit identity. Clearing the enable input leaves the mode at once. Any host-side bookkeeping of branch points across passes lives in software.

Top module: `srch_acc`

## Requirements
- R1: While reset is held and on the first cycle after it, `slot_req`, `rx_done` and `rx_byte` are all 0.
- R2: With `acc_en` low, host writes start no slots and raise no `rx_done`. Clearing `acc_en` while a byte is being processed drops `slot_req` on the next cycle, discards the byte and any held write, and no `rx_done` follows. After `acc_en` is set again, the next write is processed normally.
- R3: Each ROM position uses three slots in this order: read, read, write. `slot_op` is 0 for a read and 1 for a write. One byte therefore takes 12 slots, and a write slot is never followed directly by another write slot.
- R4: When the two reads for a position differ, the chosen bit equals the first read and the discrepancy flag is 0.
- R5: When both reads are 0, the discrepancy flag is 1 and the chosen bit for position k (k = 0..3) is bit 2k+1 of the byte the host wrote.
- R6: When both reads are 1, the discrepancy flag is 1 and the chosen bit is 1.
- R7: `slot_wbit` during each write slot equals the chosen bit for that position.
- R8: In `rx_byte`, bit 2k+1 holds the chosen bit of position k and bit 2k holds its discrepancy flag. Position 0 is the first one processed.
- R9: `rx_done` is a one-cycle pulse. It rises in the cycle after the clock edge that samples `slot_ack` for the twelfth slot, and `rx_byte` changes only in that same cycle.
- R10: `slot_req` stays high until a cycle in which `slot_ack` is high. `slot_rbit` is taken in the cycle of `slot_ack` on a read slot.
- R11: A host write made while a byte is in progress is held and started after that byte completes. A further write made while one is already held replaces the held byte.
- R12: Against a single responding device, sixteen consecutive exchanges return its 64-bit identity, four bits per exchange, with the lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Accelerator mode enable |
| tx_wr | input | 1 | One-cycle host write strobe |
| tx_byte | input | 8 | Host byte; its odd bits give the preferred direction for each position |
| rx_byte | output | 8 | Interleaved result of the last completed exchange |
| rx_done | output | 1 | One-cycle pulse when `rx_byte` is updated |
| slot_req | output | 1 | Request for a slot from the slot engine |
| slot_op | output | 1 | Slot kind: 0 read, 1 write |
| slot_wbit | output | 1 | Bit to drive in a write slot |
| slot_ack | input | 1 | Slot engine finished the requested slot |
| slot_rbit | input | 1 | Bus value sampled in a read slot, valid with `slot_ack` |

## Verification
The assertions assume that the slot engine raises `slot_ack` only while `slot_req` is high and keeps it high for a single cycle per slot. They also assume that `acc_en` is changed only from outside the block. The bench's slot engine model leaves at least one idle cycle after each acknowledge and answers only pending requests. It can hold back its acknowledge so that the mode can be cleared in the middle of a slot. Host writes are single-cycle pulses driven on the falling edge. Some of them land while a byte is in flight, to exercise holding and replacement of the held byte.

// File: rtl/srch_acc_pkg.sv
package srch_acc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_ID  = 2'd1,
        ST_RD_CMP = 2'd2,
        ST_WR_SEL = 2'd3
    } step_e;

    localparam logic OP_RD = 1'b0;
    localparam logic OP_WR = 1'b1;

    typedef struct packed {
        logic sel;
        logic disc;
    } verdict_t;

    // Branch choice for one ROM position from the bit, its complement and the host preference.
    function automatic verdict_t judge(input logic id_bit, input logic cmp_bit, input logic pref_bit);
        verdict_t v;
        if (id_bit != cmp_bit) begin
            v.sel  = id_bit;
            v.disc = 1'b0;
        end else if (!id_bit) begin
            v.sel  = pref_bit;
            v.disc = 1'b1;
        end else begin
            v.sel  = 1'b1;
            v.disc = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/srch_acc_decide.sv
module srch_acc_decide
    import srch_acc_pkg::*;
(
    input  logic     id_bit,
    input  logic     cmp_bit,
    input  logic     pref_bit,
    output verdict_t verdict
);
    always_comb verdict = judge(id_bit, cmp_bit, pref_bit);
endmodule

// File: rtl/srch_acc_seq.sv
module srch_acc_seq
    import srch_acc_pkg::*;
#(
    parameter int unsigned NIBBLE = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  tx_wr,
    input  logic [2*NIBBLE-1:0]   tx_byte,
    input  logic                  slot_ack,
    input  logic                  slot_rbit,
    input  logic                  sel_bit,
    output logic                  slot_req,
    output logic                  slot_op,
    output logic                  slot_wbit,
    output logic [((NIBBLE>1)?$clog2(NIBBLE):1)-1:0] grp,
    output logic                  id_q,
    output logic                  pref_bit,
    output logic                  cmp_stb,
    output logic                  finish
);
    localparam int unsigned BYTE_W = 2 * NIBBLE;
    localparam int unsigned IDX_W  = (NIBBLE > 1) ? $clog2(NIBBLE) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NIBBLE - 1);

    step_e             state;
    logic [BYTE_W-1:0] cur_byte;
    logic [BYTE_W-1:0] pend_byte;
    logic              pend_v;
    logic [NIBBLE-1:0] odd_bits;

    for (genvar g = 0; g < NIBBLE; g++) begin : g_odd
        assign odd_bits[g] = cur_byte[2*g+1];
    end

    assign pref_bit  = odd_bits[grp];
    assign slot_req  = (state != ST_IDLE);
    assign slot_op   = (state == ST_WR_SEL) ? OP_WR : OP_RD;
    assign slot_wbit = (state == ST_WR_SEL) & sel_bit;
    assign cmp_stb   = en & slot_ack & (state == ST_RD_CMP);
    assign finish    = en & slot_ack & (state == ST_WR_SEL) & (grp == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            grp       <= '0;
            id_q      <= 1'b0;
            cur_byte  <= '0;
            pend_byte <= '0;
            pend_v    <= 1'b0;
        end else if (!en) begin
            state  <= ST_IDLE;
            grp    <= '0;
            pend_v <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pend_v) begin
                        cur_byte <= pend_byte;
                        grp      <= '0;
                        state    <= ST_RD_ID;
                        pend_v   <= tx_wr;
                        if (tx_wr) pend_byte <= tx_byte;
                    end else if (tx_wr) begin
                        cur_byte <= tx_byte;
                        grp      <= '0;
                        state    <= ST_RD_ID;
                    end
                end
                ST_RD_ID: begin
                    if (slot_ack) begin
                        id_q  <= slot_rbit;
                        state <= ST_RD_CMP;
                    end
                end
                ST_RD_CMP: begin
                    if (slot_ack) state <= ST_WR_SEL;
                end
                default: begin
                    if (slot_ack) begin
                        if (grp == LAST) begin
                            state <= ST_IDLE;
                        end else begin
                            grp   <= grp + IDX_W'(1);
                            state <= ST_RD_ID;
                        end
                    end
                end
            endcase
            if (tx_wr && state != ST_IDLE) begin
                pend_v    <= 1'b1;
                pend_byte <= tx_byte;
            end
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        en && slot_req && !slot_ack |=> slot_req); // R10
    AST_DISABLE_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        !en |=> !slot_req); // R2
    AST_FIRST_SLOT_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_req) |-> slot_op == OP_RD); // R3
    AST_NO_WRITE_PAIR: assert property (@(posedge clk) disable iff (rst)
        en && slot_ack && slot_op == OP_WR |=> !(slot_req && slot_op == OP_WR)); // R3

endmodule

// File: rtl/srch_acc_collect.sv
module srch_acc_collect
    import srch_acc_pkg::*;
#(
    parameter int unsigned NIBBLE = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stb,
    input  logic [((NIBBLE>1)?$clog2(NIBBLE):1)-1:0] idx,
    input  verdict_t              verdict,
    input  logic                  finish,
    output logic                  cur_sel,
    output logic [2*NIBBLE-1:0]   rx_byte,
    output logic                  rx_done
);
    localparam int unsigned BYTE_W = 2 * NIBBLE;

    logic [NIBBLE-1:0] sel_v;
    logic [NIBBLE-1:0] disc_v;
    logic [BYTE_W-1:0] woven;

    for (genvar g = 0; g < NIBBLE; g++) begin : g_weave
        assign woven[2*g+1] = sel_v[g];
        assign woven[2*g]   = disc_v[g];
    end

    assign cur_sel = sel_v[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_v   <= '0;
            disc_v  <= '0;
            rx_byte <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= finish;
            if (stb) begin
                sel_v[idx]  <= verdict.sel;
                disc_v[idx] <= verdict.disc;
            end
            if (finish) rx_byte <= woven;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done); // R9
    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> rx_byte == $past(rx_byte)); // R9

endmodule

// File: rtl/srch_acc.sv
module srch_acc
    import srch_acc_pkg::*;
#(
    parameter int unsigned NIBBLE = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_en,
    input  logic                tx_wr,
    input  logic [2*NIBBLE-1:0] tx_byte,
    output logic [2*NIBBLE-1:0] rx_byte,
    output logic                rx_done,
    output logic                slot_req,
    output logic                slot_op,
    output logic                slot_wbit,
    input  logic                slot_ack,
    input  logic                slot_rbit
);
    localparam int unsigned IDX_W = (NIBBLE > 1) ? $clog2(NIBBLE) : 1;

    logic [IDX_W-1:0] grp;
    logic             id_q;
    logic             pref_bit;
    logic             cmp_stb;
    logic             finish;
    logic             cur_sel;
    verdict_t         verdict;

    srch_acc_seq #(.NIBBLE(NIBBLE)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .en        (acc_en),
        .tx_wr     (tx_wr),
        .tx_byte   (tx_byte),
        .slot_ack  (slot_ack),
        .slot_rbit (slot_rbit),
        .sel_bit   (cur_sel),
        .slot_req  (slot_req),
        .slot_op   (slot_op),
        .slot_wbit (slot_wbit),
        .grp       (grp),
        .id_q      (id_q),
        .pref_bit  (pref_bit),
        .cmp_stb   (cmp_stb),
        .finish    (finish)
    );

    srch_acc_decide decide_i (
        .id_bit   (id_q),
        .cmp_bit  (slot_rbit),
        .pref_bit (pref_bit),
        .verdict  (verdict)
    );

    srch_acc_collect #(.NIBBLE(NIBBLE)) collect_i (
        .clk     (clk),
        .rst     (rst),
        .stb     (cmp_stb),
        .idx     (grp),
        .verdict (verdict),
        .finish  (finish),
        .cur_sel (cur_sel),
        .rx_byte (rx_byte),
        .rx_done (rx_done)
    );

endmodule

// File: tb/srch_acc_tb_top.sv
module srch_acc_tb_top;

    logic       clk = 1'b0;
    logic       rst, acc_en, tx_wr;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte;
    logic       rx_done, slot_req, slot_op, slot_wbit;
    logic       slot_ack, slot_rbit;

    always #10 clk = ~clk;

    srch_acc dut_i (
        .clk(clk), .rst(rst), .acc_en(acc_en), .tx_wr(tx_wr), .tx_byte(tx_byte),
        .rx_byte(rx_byte), .rx_done(rx_done), .slot_req(slot_req), .slot_op(slot_op),
        .slot_wbit(slot_wbit), .slot_ack(slot_ack), .slot_rbit(slot_rbit)
    );

    int checks = 0, fails = 0, cyc = 0;
    int done_cnt = 0, last_wr_ack = -10, pos = 0, wcnt = 0, lat = 1;
    bit hold = 1'b0, req_seen = 1'b0, finished = 1'b0;
    bit         rd_q[$];
    bit         expw_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rx_log[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Slot engine model: answers a pending request after lat cycles, one-cycle acknowledge.
    initial begin
        slot_ack = 1'b0;
        slot_rbit = 1'b0;
        forever begin
            @(negedge clk);
            if (slot_ack) begin
                slot_ack = 1'b0;
                wcnt = 0;
            end else if (slot_req && !hold) begin
                if (wcnt < lat) wcnt++;
                else begin
                    if (pos < 2) begin
                        check(slot_op == 1'b0, "R3 expected read slot", slot_op, 0);
                        slot_rbit = (rd_q.size() > 0) ? rd_q.pop_front() : 1'b1;
                    end else begin
                        check(slot_op == 1'b1, "R3 expected write slot", slot_op, 1);
                        if (expw_q.size() == 0) check(1'b0, "R7 unexpected write slot", slot_wbit, 0);
                        else begin
                            bit ew;
                            ew = expw_q.pop_front();
                            check(slot_wbit == ew, "R7 write slot bit", slot_wbit, ew);
                        end
                        last_wr_ack = cyc;
                    end
                    pos = (pos + 1) % 3;
                    slot_ack = 1'b1;
                end
            end else wcnt = 0;
        end
    end

    // Monitor / scoreboard.
    always @(negedge clk) begin
        if (!rst && slot_req) req_seen = 1'b1;
        if (!rst && rx_done) begin
            done_cnt++;
            rx_log.push_back(rx_byte);
            if (exp_q.size() == 0) check(1'b0, "R11 unexpected rx_done", rx_byte, 0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rx_byte == e, t, rx_byte, e);
                check(cyc == last_wr_ack + 1, "R9 rx_done timing", cyc, last_wr_ack + 1);
            end
        end
    end

    // Driver: pushes read answers and expected results for one host byte.
    task automatic xfer(input logic [7:0] b, input logic [3:0] a, input logic [3:0] c, input string tag);
        logic [7:0] e;
        for (int k = 0; k < 4; k++) begin
            bit s, d;
            if (a[k] != c[k]) begin s = a[k]; d = 1'b0; end
            else if (!a[k])   begin s = b[2*k+1]; d = 1'b1; end
            else              begin s = 1'b1; d = 1'b1; end
            rd_q.push_back(a[k]);
            rd_q.push_back(c[k]);
            expw_q.push_back(s);
            e[2*k+1] = s;
            e[2*k]   = d;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic hwrite(input logic [7:0] b);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_byte = b;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 exchange finished", exp_q.size(), 0);
    endtask

    task automatic one(input logic [7:0] b, input logic [3:0] a, input logic [3:0] c, input string tag);
        xfer(b, a, c, tag);
        hwrite(b);
        drain();
    endtask

    initial begin
        int base;
        logic [63:0] rom, got;
        rst = 1'b1; acc_en = 1'b0; tx_wr = 1'b0; tx_byte = '0;
        repeat (3) @(negedge clk);
        check(slot_req == 1'b0, "R1 slot_req in reset", slot_req, 0);
        check(rx_done == 1'b0, "R1 rx_done in reset", rx_done, 0);
        check(rx_byte == 8'h00, "R1 rx_byte in reset", rx_byte, 0);
        rst = 1'b0;
        @(negedge clk);
        check(slot_req == 1'b0 && rx_done == 1'b0 && rx_byte == 8'h00, "R1 after reset", rx_byte, 0);

        // R2: writes with the mode off start nothing.
        hwrite(8'hA5);
        repeat (20) @(negedge clk);
        check(!req_seen, "R2 no slot while disabled", req_seen, 0);
        check(done_cnt == 0, "R2 no rx_done while disabled", done_cnt, 0);

        acc_en = 1'b1;
        @(negedge clk);
        one(8'h00, 4'b1010, 4'b0101, "R4 reads differ");
        one(8'hAA, 4'b0000, 4'b0000, "R5 both zero, preference ones");
        one(8'h28, 4'b0000, 4'b0000, "R5 both zero, mixed preference");
        one(8'h00, 4'b1111, 4'b1111, "R6 both one");
        one(8'h80, 4'b0011, 4'b0101, "R8 mixed positions");
        lat = 3;
        one(8'h02, 4'b0110, 4'b1000, "R10 slow slot engine");
        lat = 1;

        // R11: held write runs after the current one.
        base = done_cnt;
        xfer(8'h00, 4'b0000, 4'b0000, "R11 first of two");
        xfer(8'hAA, 4'b0000, 4'b0000, "R11 held byte");
        hwrite(8'h00);
        repeat (3) @(negedge clk);
        hwrite(8'hAA);
        drain();
        check(done_cnt - base == 2, "R11 two results", done_cnt - base, 2);

        // R11: a second held write replaces the first held one.
        base = done_cnt;
        xfer(8'h00, 4'b0000, 4'b0000, "R11 running byte");
        xfer(8'h8A, 4'b0000, 4'b0000, "R11 replacing byte");
        hwrite(8'h00);
        repeat (2) @(negedge clk);
        hwrite(8'h20);
        hwrite(8'h8A);
        drain();
        check(done_cnt - base == 2, "R11 replaced byte dropped", done_cnt - base, 2);

        // R12: sixteen exchanges against one device.
        rom = 64'hC3A1_5E07_9B24_F168;
        base = rx_log.size();
        for (int i = 0; i < 16; i++) begin
            logic [3:0] nib;
            nib = rom[4*i +: 4];
            one(8'h00, nib, ~nib, "R12 identity nibble");
        end
        got = '0;
        for (int i = 0; i < 16; i++) begin
            logic [7:0] rb;
            rb = (base + i < rx_log.size()) ? rx_log[base + i] : 8'h00;
            got[4*i +: 4] = {rb[7], rb[5], rb[3], rb[1]};
        end
        check(got == rom, "R12 assembled identity", int'(got[31:0]), int'(rom[31:0]));
        check(got[63:32] == rom[63:32], "R12 assembled identity high", int'(got[63:32]), int'(rom[63:32]));

        // R2: leaving the mode in the middle of a slot.
        hold = 1'b1;
        base = done_cnt;
        hwrite(8'h00);
        repeat (3) @(negedge clk);
        check(slot_req == 1'b1, "R2 request pending before abort", slot_req, 1);
        acc_en = 1'b0;
        @(negedge clk);
        check(slot_req == 1'b0, "R2 request dropped after abort", slot_req, 0);
        hold = 1'b0;
        repeat (30) @(negedge clk);
        check(done_cnt == base, "R2 no result after abort", done_cnt - base, 0);
        pos = 0;
        acc_en = 1'b1;
        @(negedge clk);
        one(8'h00, 4'b1100, 4'b0011, "R2 recovery after abort");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R3 run did not end actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule